// File: doc/BRIEF.md
# Variable-Frame Register Stack Manager

This block owns a 128-entry, 64-bit integer register file and turns its upper 96 entries into a circular stack of procedure frames whose size each procedure picks at run time. Logical registers 0 to 31 are static and always address the same physical entry. A logical register from 32 upward is relocated by the base of the running frame and wraps around inside the 96 stacked entries. Two read ports and one write port take logical numbers, and each port reports when its number lies past the end of the running frame.

A call makes the caller's output registers the callee's first stacked registers. The callee starts with no locals and grows its frame with an allocate command. A return restores the caller's base, size and output start from a record stack. The block counts how many stacked entries are resident. When an allocate would need more than 96 resident entries, it asks an external spill engine to save the oldest entries, one per handshake. When a return finds that part of the caller's frame was saved earlier, it asks for those entries back, newest first, before it signals that the return is complete. Moving data to and from memory is the spill engine's job and is not part of this block.

Top module: `regstack_mgr`

## Requirements
- R1: A logical register below 32 reaches physical entry of the same number whatever the frame state, so a value written there is read back unchanged after a call.
- R2: A logical register r with 32 <= r < 32 + frame size reaches physical entry 32 + ((base + r - 32) mod 96), so a frame that runs past the top of the stacked area continues at entry 32.
- R3: A logical register at or above 32 + frame size raises the illegal flag of its port (ill_rd_a, ill_rd_b, ill_wr). A write flagged illegal leaves the register file unchanged.
- R4: A call (cmd_op 2'b01) moves the base forward by the caller's output start, modulo 96. It sets the frame size to the caller's size minus its output start and sets the output start to 0.
- R5: An allocate (cmd_op 2'b10) sets the frame size to cmd_size and the output start to cmd_outs. If cmd_size is greater than 96 or cmd_outs is greater than cmd_size, the block pulses cmd_err for one cycle and the frame is left unchanged. cmd_op 2'b00 does nothing.
- R6: used_cnt counts the stacked entries from the oldest resident one to the top of the running frame and never exceeds 96. An allocate that would push it past 96 raises spill_req, oldest entry first, with spill_idx = 32 + (oldest position mod 96). Each spill_ack saves one entry. cmd_ready stays low until the allocate has taken effect. spilled_cnt counts the entries that are held in memory.
- R7: A return (cmd_op 2'b11) restores the caller's base, size and output start exactly. If some of the caller's entries are held in memory, the block raises fill_req with fill_idx = 32 + (newest saved position mod 96), takes one entry per fill_ack until the caller's base is resident again, and then pulses ret_done. Without a fill, ret_done pulses in the cycle after the command is accepted.
- R8: A return with no saved frame record, or a call when all REC_DEPTH records are in use, pulses cmd_err and leaves the frame unchanged.
- R9: After reset the base, frame size, output start, used_cnt and spilled_cnt are 0, cmd_ready is high, and neither request is raised.
- R10: A write can be read back on the next cycle. A read of the address being written in the same cycle returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present; accepted when cmd_ready is high |
| cmd_op | input | 2 | 00 none, 01 call, 10 allocate, 11 return |
| cmd_size | input | 7 | Allocate: new frame size |
| cmd_outs | input | 7 | Allocate: offset where the output registers start |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_err | output | 1 | One-cycle pulse: command rejected |
| ret_done | output | 1 | One-cycle pulse: return complete |
| spill_req | output | 1 | Request to save one stacked entry |
| spill_idx | output | 7 | Physical entry to save |
| spill_ack | input | 1 | Entry saved |
| fill_req | output | 1 | Request to restore one stacked entry |
| fill_idx | output | 7 | Physical entry to restore |
| fill_ack | input | 1 | Entry restored |
| rd_addr_a | input | 7 | Logical register, read port A |
| rd_data_a | output | 64 | Read data, port A |
| ill_rd_a | output | 1 | Port A number lies outside the frame |
| rd_addr_b | input | 7 | Logical register, read port B |
| rd_data_b | output | 64 | Read data, port B |
| ill_rd_b | output | 1 | Port B number lies outside the frame |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 7 | Logical register to write |
| wr_data | input | 64 | Write data |
| ill_wr | output | 1 | Write number lies outside the frame; write dropped |
| frame_base | output | 7 | Base of the running frame, 0 to 95 |
| frame_size | output | 7 | Stacked registers in the running frame |
| frame_outs | output | 7 | Offset of the output registers in the running frame |
| used_cnt | output | 7 | Resident stacked entries |
| spilled_cnt | output | 16 | Stacked entries held in memory |

## Verification
The embedded properties assume that the spill engine raises spill_ack only while spill_req is high and fill_ack only while fill_req is high, and that the caller never pushes more frames than the record stack holds without heeding cmd_err. The bench keeps to these assumptions. It sets each acknowledge at the falling edge, straight from the request it sees there, and drops it once the request goes away. It offers a new command only while cmd_ready is high. The stimulus walks a nested call chain deep enough to force spills and the fills that follow. It also covers a frame that wraps past entry 127, illegal and static accesses, same-cycle bypass, and rejected commands.

// File: rtl/regstack_pkg.sv
// Shared encodings for the register stack manager.
// Assumes: command codes are fixed by the port contract (2 bits).
package regstack_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_CALL  = 2'b01,
        OP_ALLOC = 2'b10,
        OP_RET   = 2'b11
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SPILL = 2'b01,
        ST_FILL  = 2'b10
    } ctl_state_e;

endpackage

// File: rtl/regstack_map.sv
// Logical-to-physical register translation for one port.
// Static registers pass through. Stacked registers are offset by the frame
// base and wrap inside the stacked area. Flags numbers past the frame end.
// Assumes: base_mod < N_STACK and sof <= N_STACK.
module regstack_map #(
    parameter int N_STATIC = 32,
    parameter int N_STACK  = 96,
    localparam int AW  = $clog2(N_STATIC + N_STACK),
    localparam int AW1 = AW + 1,
    localparam int SW  = $clog2(N_STACK + 1),
    localparam int BW  = $clog2(N_STACK)
) (
    input  logic [BW-1:0] base_mod,
    input  logic [SW-1:0] sof,
    input  logic [AW-1:0] lreg,
    output logic [AW-1:0] preg,
    output logic          illegal
);

    logic [AW1-1:0] limit;
    logic [AW1-1:0] offs;
    logic [AW1-1:0] sum;
    logic [AW1-1:0] wrapped;

    // Translate the logical number and test it against the frame end.
    always_comb begin
        limit   = AW1'(N_STATIC) + AW1'(sof);
        illegal = ({1'b0, lreg} >= limit);
        offs    = {1'b0, lreg} - AW1'(N_STATIC);
        sum     = AW1'(base_mod) + offs;
        wrapped = (sum >= AW1'(N_STACK)) ? (sum - AW1'(N_STACK)) : sum;
        preg    = (lreg < AW'(N_STATIC)) ? lreg : AW'(AW1'(N_STATIC) + wrapped);
    end

endmodule

// File: rtl/regstack_rf.sv
// Physical register file: NRD combinational read ports, one write port.
// A read of the entry being written in the same cycle returns the new data.
// Assumes: waddr and raddr are physical indices below DEPTH.
module regstack_rf #(
    parameter int XLEN  = 64,
    parameter int DEPTH = 128,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   raddr [NRD],
    output logic [XLEN-1:0] rdata [NRD]
);

    logic [XLEN-1:0] mem [DEPTH];

    // Store write data at the clock edge.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Read with bypass from the write port.
        assign rdata[p] = (we && (waddr == raddr[p])) ? wdata : mem[raddr[p]];

        // R10
        rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(we) && (raddr[p] == $past(waddr)) && !(we && (waddr == raddr[p])))
            |-> (rdata[p] == $past(wdata)));
    end

endmodule

// File: rtl/regstack_frames.sv
// LIFO of caller frame records (absolute base, size, output start).
// Pushed on call, popped on return; top entry visible combinationally.
// Assumes: the controller never pushes when full nor pops when empty.
module regstack_frames #(
    parameter int DEPTH = 8,
    parameter int ABS_W = 16,
    parameter int SW    = 7,
    localparam int PW   = $clog2(DEPTH + 1),
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [ABS_W-1:0] in_base,
    input  logic [SW-1:0]    in_sof,
    input  logic [SW-1:0]    in_sol,
    output logic [ABS_W-1:0] out_base,
    output logic [SW-1:0]    out_sof,
    output logic [SW-1:0]    out_sol,
    output logic             empty,
    output logic             full
);

    logic [ABS_W-1:0] base_q [DEPTH];
    logic [SW-1:0]    sof_q  [DEPTH];
    logic [SW-1:0]    sol_q  [DEPTH];
    logic [PW-1:0]    cnt;
    logic [IW-1:0]    top_i;

    assign empty = (cnt == '0);
    assign full  = (cnt == PW'(DEPTH));
    assign top_i = IW'(cnt - PW'(1));

    // Track the number of stored records.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push) begin
            cnt <= cnt + PW'(1);
        end else if (pop) begin
            cnt <= cnt - PW'(1);
        end
    end

    // Write the pushed record into the next free slot.
    always_ff @(posedge clk) begin
        if (push) begin
            base_q[IW'(cnt)] <= in_base;
            sof_q[IW'(cnt)]  <= in_sof;
            sol_q[IW'(cnt)]  <= in_sol;
        end
    end

    // Present the newest record.
    always_comb begin
        out_base = empty ? '0 : base_q[top_i];
        out_sof  = empty ? '0 : sof_q[top_i];
        out_sol  = empty ? '0 : sol_q[top_i];
    end

    // R8
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
    // R8
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);

endmodule

// File: rtl/regstack_mgr.sv
// Variable-frame register stack manager (top).
// Holds the running frame (absolute base, size, output start) and the
// absolute position of the oldest resident stacked entry. Sequences the
// spill handshake on allocate and the fill handshake on return.
// Assumes: spill_ack only while spill_req, fill_ack only while fill_req;
// absolute positions never exceed 2**ABS_W over a run.
module regstack_mgr
    import regstack_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int N_STATIC  = 32,
    parameter int N_STACK   = 96,
    parameter int REC_DEPTH = 8,
    parameter int ABS_W     = 16,
    localparam int N_PHYS   = N_STATIC + N_STACK,
    localparam int AW       = $clog2(N_PHYS),
    localparam int SW       = $clog2(N_STACK + 1),
    localparam int BW       = $clog2(N_STACK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [SW-1:0]    cmd_size,
    input  logic [SW-1:0]    cmd_outs,
    output logic             cmd_ready,
    output logic             cmd_err,
    output logic             ret_done,
    output logic             spill_req,
    output logic [AW-1:0]    spill_idx,
    input  logic             spill_ack,
    output logic             fill_req,
    output logic [AW-1:0]    fill_idx,
    input  logic             fill_ack,
    input  logic [AW-1:0]    rd_addr_a,
    output logic [XLEN-1:0]  rd_data_a,
    output logic             ill_rd_a,
    input  logic [AW-1:0]    rd_addr_b,
    output logic [XLEN-1:0]  rd_data_b,
    output logic             ill_rd_b,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [XLEN-1:0]  wr_data,
    output logic             ill_wr,
    output logic [BW-1:0]    frame_base,
    output logic [SW-1:0]    frame_size,
    output logic [SW-1:0]    frame_outs,
    output logic [SW-1:0]    used_cnt,
    output logic [ABS_W-1:0] spilled_cnt
);

    localparam int NLANE = 3;

    ctl_state_e       state;
    stk_op_e          op_in;
    logic [ABS_W-1:0] base_abs;
    logic [ABS_W-1:0] bot_abs;
    logic [SW-1:0]    sof;
    logic [SW-1:0]    sol;
    logic [SW-1:0]    pend_sof;
    logic [SW-1:0]    pend_sol;
    logic [ABS_W-1:0] top_abs;
    logic [ABS_W-1:0] used_abs;
    logic [ABS_W-1:0] grow_used;
    logic [ABS_W-1:0] pend_used;
    logic [BW-1:0]    base_mod;
    logic [BW-1:0]    bot_mod;
    logic [BW-1:0]    newest_mod;
    logic             alloc_ok;
    logic             idle_cmd;
    logic             rec_push;
    logic             rec_pop;
    logic [ABS_W-1:0] rec_base;
    logic [SW-1:0]    rec_sof;
    logic [SW-1:0]    rec_sol;
    logic             rec_empty;
    logic             rec_full;

    // Derived positions and occupancy.
    always_comb begin
        op_in      = stk_op_e'(cmd_op);
        top_abs    = base_abs + ABS_W'(sof);
        used_abs   = top_abs - bot_abs;
        grow_used  = base_abs + ABS_W'(cmd_size) - bot_abs;
        pend_used  = base_abs + ABS_W'(pend_sof) - bot_abs;
        base_mod   = BW'(base_abs % ABS_W'(N_STACK));
        bot_mod    = BW'(bot_abs % ABS_W'(N_STACK));
        newest_mod = BW'((bot_abs - ABS_W'(1)) % ABS_W'(N_STACK));
        alloc_ok   = (cmd_size <= SW'(N_STACK)) && (cmd_outs <= cmd_size);
        idle_cmd   = cmd_valid && (state == ST_IDLE);
        rec_push   = idle_cmd && (op_in == OP_CALL) && !rec_full;
        rec_pop    = idle_cmd && (op_in == OP_RET) && !rec_empty;
    end

    // Handshake outputs and status.
    assign cmd_ready   = (state == ST_IDLE);
    assign spill_req   = (state == ST_SPILL) && (pend_used > ABS_W'(N_STACK));
    assign fill_req    = (state == ST_FILL) && (bot_abs > base_abs);
    assign spill_idx   = AW'(N_STATIC) + AW'(bot_mod);
    assign fill_idx    = AW'(N_STATIC) + AW'(newest_mod);
    assign frame_base  = base_mod;
    assign frame_size  = sof;
    assign frame_outs  = sol;
    assign used_cnt    = SW'(used_abs);
    assign spilled_cnt = bot_abs;

    // Frame state machine: commands, spill and fill sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            base_abs <= '0;
            bot_abs  <= '0;
            sof      <= '0;
            sol      <= '0;
            pend_sof <= '0;
            pend_sol <= '0;
            cmd_err  <= 1'b0;
            ret_done <= 1'b0;
        end else begin
            cmd_err  <= 1'b0;
            ret_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        unique case (op_in)
                            OP_CALL: begin
                                if (rec_full) begin
                                    cmd_err <= 1'b1;
                                end else begin
                                    base_abs <= base_abs + ABS_W'(sol);
                                    sof      <= sof - sol;
                                    sol      <= '0;
                                end
                            end
                            OP_ALLOC: begin
                                if (!alloc_ok) begin
                                    cmd_err <= 1'b1;
                                end else if (grow_used > ABS_W'(N_STACK)) begin
                                    pend_sof <= cmd_size;
                                    pend_sol <= cmd_outs;
                                    state    <= ST_SPILL;
                                end else begin
                                    sof <= cmd_size;
                                    sol <= cmd_outs;
                                end
                            end
                            OP_RET: begin
                                if (rec_empty) begin
                                    cmd_err <= 1'b1;
                                end else begin
                                    base_abs <= rec_base;
                                    sof      <= rec_sof;
                                    sol      <= rec_sol;
                                    if (rec_base < bot_abs) begin
                                        state <= ST_FILL;
                                    end else begin
                                        ret_done <= 1'b1;
                                    end
                                end
                            end
                            default: begin
                            end
                        endcase
                    end
                end
                ST_SPILL: begin
                    if (spill_req) begin
                        if (spill_ack) begin
                            bot_abs <= bot_abs + ABS_W'(1);
                        end
                    end else begin
                        sof   <= pend_sof;
                        sol   <= pend_sol;
                        state <= ST_IDLE;
                    end
                end
                ST_FILL: begin
                    if (fill_req) begin
                        if (fill_ack) begin
                            bot_abs <= bot_abs - ABS_W'(1);
                        end
                    end else begin
                        ret_done <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    regstack_frames #(
        .DEPTH (REC_DEPTH),
        .ABS_W (ABS_W),
        .SW    (SW)
    ) u_frames (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rec_push),
        .pop      (rec_pop),
        .in_base  (base_abs),
        .in_sof   (sof),
        .in_sol   (sol),
        .out_base (rec_base),
        .out_sof  (rec_sof),
        .out_sol  (rec_sol),
        .empty    (rec_empty),
        .full     (rec_full)
    );

    // Register port translation: lanes 0/1 read, lane 2 write.
    logic [AW-1:0]   lane_l   [NLANE];
    logic [AW-1:0]   lane_p   [NLANE];
    logic            lane_ill [NLANE];
    logic [AW-1:0]   rf_raddr [2];
    logic [XLEN-1:0] rf_rdata [2];

    assign lane_l[0] = rd_addr_a;
    assign lane_l[1] = rd_addr_b;
    assign lane_l[2] = wr_addr;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        regstack_map #(
            .N_STATIC (N_STATIC),
            .N_STACK  (N_STACK)
        ) u_map (
            .base_mod (base_mod),
            .sof      (sof),
            .lreg     (lane_l[i]),
            .preg     (lane_p[i]),
            .illegal  (lane_ill[i])
        );
    end

    assign rf_raddr[0] = lane_p[0];
    assign rf_raddr[1] = lane_p[1];
    assign rd_data_a   = rf_rdata[0];
    assign rd_data_b   = rf_rdata[1];
    assign ill_rd_a    = lane_ill[0];
    assign ill_rd_b    = lane_ill[1];
    assign ill_wr      = lane_ill[2];

    regstack_rf #(
        .XLEN  (XLEN),
        .DEPTH (N_PHYS),
        .NRD   (2)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && !lane_ill[2]),
        .waddr (lane_p[2]),
        .wdata (wr_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    // R6
    used_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used_abs <= ABS_W'(N_STACK));
    // R6
    spill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_req && !spill_ack) |=> (spill_req && $stable(spill_idx)));
    // R6
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_req || fill_req) |-> !cmd_ready);
    // R4
    call_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_push |=> ((sof == $past(sof - sol)) && (sol == '0)
                      && (base_abs == $past(base_abs + ABS_W'(sol)))));
    // R7
    ret_resident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |-> (!fill_req && (bot_abs <= base_abs) && cmd_ready));
    // R6
    spill_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spill_ack |-> spill_req);

endmodule

// File: tb/regstack_mgr_test.sv
module regstack_mgr_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [6:0]  cmd_size = '0;
    logic [6:0]  cmd_outs = '0;
    logic        cmd_ready, cmd_err, ret_done;
    logic        spill_req, fill_req;
    logic [6:0]  spill_idx, fill_idx;
    logic        spill_ack = 1'b0;
    logic        fill_ack = 1'b0;
    logic [6:0]  rd_addr_a = '0;
    logic [6:0]  rd_addr_b = '0;
    logic [63:0] rd_data_a, rd_data_b;
    logic        ill_rd_a, ill_rd_b, ill_wr;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [6:0]  frame_base, frame_size, frame_outs, used_cnt;
    logic [15:0] spilled_cnt;

    int checks = 0;
    int errors = 0;
    int n_spill, n_fill, first_idx;
    logic saw_done, saw_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    regstack_mgr uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_size(cmd_size), .cmd_outs(cmd_outs),
        .cmd_ready(cmd_ready), .cmd_err(cmd_err), .ret_done(ret_done),
        .spill_req(spill_req), .spill_idx(spill_idx), .spill_ack(spill_ack),
        .fill_req(fill_req), .fill_idx(fill_idx), .fill_ack(fill_ack),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a), .ill_rd_a(ill_rd_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .ill_rd_b(ill_rd_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ill_wr(ill_wr),
        .frame_base(frame_base), .frame_size(frame_size), .frame_outs(frame_outs),
        .used_cnt(used_cnt), .spilled_cnt(spilled_cnt)
    );

    // op, size, outs, then expected base, size, outs, used, spills, fills, first idx, spilled
    typedef struct packed {
        logic [1:0] op;
        logic [7:0] size, outs, e_base, e_sof, e_sol, e_used, e_spill, e_fill, e_idx, e_spilled;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{2'd2, 8'd20, 8'd16,  8'd0, 8'd20, 8'd16, 8'd20,  8'd0,  8'd0,  8'd0,  8'd0},
        '{2'd1,  8'd0,  8'd0, 8'd16,  8'd4,  8'd0, 8'd20,  8'd0,  8'd0,  8'd0,  8'd0},
        '{2'd2, 8'd60, 8'd50, 8'd16, 8'd60, 8'd50, 8'd76,  8'd0,  8'd0,  8'd0,  8'd0},
        '{2'd1,  8'd0,  8'd0, 8'd66, 8'd10,  8'd0, 8'd76,  8'd0,  8'd0,  8'd0,  8'd0},
        '{2'd2, 8'd40, 8'd30, 8'd66, 8'd40, 8'd30, 8'd96, 8'd10,  8'd0, 8'd32, 8'd10},
        '{2'd1,  8'd0,  8'd0,  8'd0, 8'd10,  8'd0, 8'd96,  8'd0,  8'd0,  8'd0, 8'd10},
        '{2'd2, 8'd30, 8'd30,  8'd0, 8'd30, 8'd30, 8'd96, 8'd20,  8'd0, 8'd42, 8'd30},
        '{2'd3,  8'd0,  8'd0, 8'd66, 8'd40, 8'd30, 8'd76,  8'd0,  8'd0,  8'd0, 8'd30},
        '{2'd3,  8'd0,  8'd0, 8'd16, 8'd60, 8'd50, 8'd60,  8'd0, 8'd14, 8'd61, 8'd16},
        '{2'd3,  8'd0,  8'd0,  8'd0, 8'd20, 8'd16, 8'd20,  8'd0, 8'd16, 8'd47,  8'd0}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Issue one command and serve spill/fill handshakes until idle again.
    task automatic do_cmd(input logic [1:0] op, input logic [6:0] size, input logic [6:0] outs);
        n_spill = 0; n_fill = 0; first_idx = 0; saw_done = 1'b0; saw_err = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_size = size; cmd_outs = outs;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        forever begin
            if (ret_done) saw_done = 1'b1;
            if (cmd_err) saw_err = 1'b1;
            spill_ack = spill_req;
            fill_ack  = fill_req;
            if (spill_req) begin
                n_spill++;
                if (first_idx == 0) first_idx = int'(spill_idx);
            end
            if (fill_req) begin
                n_fill++;
                if (first_idx == 0) first_idx = int'(fill_idx);
            end
            if (cmd_ready && !spill_req && !fill_req) break;
            @(negedge clk);
        end
        spill_ack = 1'b0;
        fill_ack  = 1'b0;
    endtask

    task automatic wr_reg(input logic [6:0] r, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = r; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [6:0] r, output logic [63:0] d, output logic ill);
        @(negedge clk);
        rd_addr_a = r;
        #1;
        d = rd_data_a;
        ill = ill_rd_a;
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [63:0] d;
        logic ill;
        string tag;

        do_reset();
        // R9 reset state
        check("R9 base", 64'(frame_base), 64'd0);
        check("R9 size", 64'(frame_size), 64'd0);
        check("R9 outs", 64'(frame_outs), 64'd0);
        check("R9 used", 64'(used_cnt), 64'd0);
        check("R9 spilled", 64'(spilled_cnt), 64'd0);
        check("R9 ready/req", {61'd0, cmd_ready, spill_req, fill_req}, 64'b100);

        // Table walk: nested calls, spills on allocate, fills on return
        for (int i = 0; i < NVEC; i++) begin
            do_cmd(VEC[i].op, VEC[i].size[6:0], VEC[i].outs[6:0]);
            tag = (VEC[i].op == 2'd1) ? "R4" : (VEC[i].op == 2'd2) ? "R5" : "R7";
            check($sformatf("%s row%0d base", tag, i), 64'(frame_base), 64'(VEC[i].e_base));
            check($sformatf("%s row%0d size", tag, i), 64'(frame_size), 64'(VEC[i].e_sof));
            check($sformatf("%s row%0d outs", tag, i), 64'(frame_outs), 64'(VEC[i].e_sol));
            check($sformatf("R6 row%0d used", i), 64'(used_cnt), 64'(VEC[i].e_used));
            check($sformatf("R6 row%0d spills", i), 64'(n_spill), 64'(VEC[i].e_spill));
            check($sformatf("R7 row%0d fills", i), 64'(n_fill), 64'(VEC[i].e_fill));
            check($sformatf("R6 row%0d first idx", i), 64'(first_idx), 64'(VEC[i].e_idx));
            check($sformatf("R6 row%0d spilled", i), 64'(spilled_cnt), 64'(VEC[i].e_spilled));
            check($sformatf("R7 row%0d ret_done", i), 64'(saw_done), 64'(VEC[i].op == 2'd3));
        end

        // R8: return with no record is rejected
        do_cmd(2'd3, 7'd0, 7'd0);
        check("R8 ret empty err", 64'(saw_err), 64'd1);
        check("R8 ret empty size kept", 64'(frame_size), 64'd20);

        // R5: bad allocate sizes are rejected
        do_cmd(2'd2, 7'd97, 7'd0);
        check("R5 size>96 err", 64'(saw_err), 64'd1);
        do_cmd(2'd2, 7'd10, 7'd11);
        check("R5 outs>size err", 64'(saw_err), 64'd1);
        check("R5 size kept", 64'(frame_size), 64'd20);
        do_cmd(2'd0, 7'd5, 7'd1);
        check("R5 no-op keeps size", 64'(frame_size), 64'd20);

        // R3: write past frame end is flagged and dropped
        do_cmd(2'd2, 7'd21, 7'd16);
        wr_reg(7'd52, 64'h1111);
        do_cmd(2'd2, 7'd20, 7'd16);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'd52; wr_data = 64'h2222;
        #1;
        check("R3 ill_wr", 64'(ill_wr), 64'd1);
        @(negedge clk);
        wr_en = 1'b0;
        rd_reg(7'd52, d, ill);
        check("R3 ill_rd_a", 64'(ill), 64'd1);
        do_cmd(2'd2, 7'd21, 7'd16);
        rd_reg(7'd52, d, ill);
        check("R3 dropped write", d, 64'h1111);
        rd_addr_b = 7'd52;
        #1;
        check("R10 port b readback", rd_data_b, 64'h1111);
        check("R3 ill_rd_b clear", 64'(ill_rd_b), 64'd0);

        // R1: static register survives a call
        wr_reg(7'd5, 64'h55AA);
        do_cmd(2'd1, 7'd0, 7'd0);
        rd_reg(7'd5, d, ill);
        check("R1 static after call", d, 64'h55AA);
        check("R1 static legal", 64'(ill), 64'd0);
        do_cmd(2'd3, 7'd0, 7'd0);

        // R10: same-cycle bypass and next-cycle readback
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'd33; wr_data = 64'h77; rd_addr_a = 7'd33;
        #1;
        check("R10 bypass", rd_data_a, 64'h77);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R10 next cycle", rd_data_a, 64'h77);

        // R2: a frame wrapping past entry 127 aliases the caller's entry 36
        do_reset();
        do_cmd(2'd2, 7'd40, 7'd30);
        do_cmd(2'd1, 7'd0, 7'd0);
        check("R4 base after call", 64'(frame_base), 64'd30);
        do_cmd(2'd2, 7'd80, 7'd0);
        check("R6 spills for wrap frame", 64'(n_spill), 64'd14);
        wr_reg(7'd102, 64'hC0FFEE);
        do_cmd(2'd3, 7'd0, 7'd0);
        check("R7 fills after wrap", 64'(n_fill), 64'd14);
        rd_reg(7'd36, d, ill);
        check("R2 wrapped alias", d, 64'hC0FFEE);

        // R8: call with all records in use is rejected
        do_reset();
        for (int k = 0; k < 8; k++) begin
            do_cmd(2'd1, 7'd0, 7'd0);
            check($sformatf("R8 call %0d accepted", k), 64'(saw_err), 64'd0);
        end
        do_cmd(2'd1, 7'd0, 7'd0);
        check("R8 call full err", 64'(saw_err), 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule